// File: doc/BRIEF.md
# Latched Interrupt Controller with Acknowledge-Mask Register

This block gathers interrupt causes for a line-interface device and presents them to a host as one active-low, latched request line. There are two kinds of cause. Each bit of a status word raises a cause on every change of value, whether the bit rises or falls. Two elastic-store condition flags, overflow and underflow, raise a cause for as long as they are held high. A cause that meets an unmasked source while interrupts are globally enabled sets a pending flag. The flag stays set after the cause has gone, and the request line stays low while any pending flag is set and the global enable is on.

The host reaches the block through a simple synchronous register port with a combinational read path. One write-only register serves both to acknowledge and to mask. Writing 1 to a bit of it acknowledges that source and keeps the source masked until the host writes 0 to the bit again. An acknowledge takes effect only when the source's cause is absent. If the cause is still present, the flag stays pending and clears on the first clock edge at which the cause is gone, as long as the mask bit is still 1. A control register holds the global enable, and a read-only register shows the pending flags.

The reset input is asynchronous and active low. The block releases it synchronously through its own two-stage synchronizer.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset all pending flags are 0, all mask bits are 0, the global enable (control register at address 0, bit 0) is 0 and `irq_n_o` is 1.
- R2: While enabled and unmasked, a rise or a fall of status bit i sets pending bit i on the clock edge that first samples the new value. The pending register is at address 2: bits 0..NUM_STAT-1 are the status bits, bit NUM_STAT is overflow and bit NUM_STAT+1 is underflow. `irq_n_o` goes to 0 after that edge.
- R3: While enabled and unmasked, a high level on `es_ovf_i` sets pending bit NUM_STAT and a high level on `es_unf_i` sets pending bit NUM_STAT+1.
- R4: A pending flag whose source is unmasked stays set after its cause has gone.
- R5: A write of 1 to bit i of the acknowledge-mask register (address 1) clears pending bit i on the same clock edge when cause i is absent. Once no other flag is pending, `irq_n_o` returns to 1.
- R6: An acknowledge written while cause i is present leaves pending bit i set. The bit then clears on the first edge at which cause i is absent while mask bit i is 1.
- R7: While mask bit i is 1, cause i does not set pending bit i.
- R8: Writing 0 to mask bit i re-enables the source, so a later cause sets pending bit i again.
- R9: While the global enable is 0, `irq_n_o` is 1 and no pending flag is set. Pending flags that already exist are kept and drive `irq_n_o` low again once the enable is set to 1.
- R10: A read of address 1 or address 3 returns 0. A read of address 0 returns the enable in bit 0 and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_a | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stat_i | input | NUM_STAT | Status word; any change of a bit is a cause |
| es_ovf_i | input | 1 | Elastic-store overflow flag, level cause |
| es_unf_i | input | 1 | Elastic-store underflow flag, level cause |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | ADDR_W | Register address: 0 control, 1 acknowledge-mask, 2 pending |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Combinational read data for `reg_addr_i` |
| irq_n_o | output | 1 | Latched interrupt request, active low |

## Verification
Two functions can act in the same cycle: an acknowledge write, which tries to clear a flag, and a live cause, which tries to hold it. The bench provokes this by writing the acknowledge while the overflow flag is held high. It then expects the pending bit to survive that edge and to clear only on the edge after the flag is dropped. The same collision is provoked with a mask write that lands while a status bit toggles, and there the bench expects no pending flag to be set. A checker also watches every edge: it requires that a flag never clears while its cause is live and never sets through a mask bit.

// File: rtl/irq_latch_ctrl_pkg.sv
package irq_latch_ctrl_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned EN_BIT = 0;

  function automatic reg_sel_e decode_addr(input logic [1:0] a);
    case (a)
      2'd0:    decode_addr = SEL_CTRL;
      2'd1:    decode_addr = SEL_ACK;
      2'd2:    decode_addr = SEL_PEND;
      default: decode_addr = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_latch_ctrl_rst_sync.sv
module irq_latch_ctrl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_a,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_a) begin
    if (!rst_n_a) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/irq_latch_ctrl_cause_gen.sv
module irq_latch_ctrl_cause_gen #(
  parameter int unsigned NUM_STAT = 6,
  localparam int unsigned NSRC = NUM_STAT + 2
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic [NUM_STAT-1:0] stat_i,
  input  logic                es_ovf_i,
  input  logic                es_unf_i,
  output logic [NSRC-1:0]     cause_o
);

  logic [NUM_STAT-1:0] stat_q;
  logic [NUM_STAT-1:0] stat_d;
  logic [NUM_STAT-1:0] chg;

  always_comb begin
    stat_d = stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  // A status cause lasts one cycle per transition, in either direction.
  genvar g;
  generate
    for (g = 0; g < NUM_STAT; g++) begin : g_chg
      assign chg[g] = stat_i[g] ^ stat_q[g];
    end
  endgenerate

  assign cause_o = {es_unf_i, es_ovf_i, chg};

endmodule

// File: rtl/irq_latch_ctrl_host_regs.sv
module irq_latch_ctrl_host_regs
  import irq_latch_ctrl_pkg::*;
#(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [NSRC-1:0]   mask_eff_o
);

  reg_sel_e        sel;
  logic            en_q, en_d, en_ce;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            mask_ce;
  logic [DATA_W-1:0] pend_ext;

  assign sel = decode_addr(addr_i[1:0]);

  // Next state, with the clock enables written out.
  always_comb begin
    en_ce   = wr_i && (sel == SEL_CTRL);
    mask_ce = wr_i && (sel == SEL_ACK);
    en_d    = en_ce ? wdata_i[EN_BIT] : en_q;
    mask_d  = mask_ce ? wdata_i[NSRC-1:0] : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      if (en_ce) begin
        en_q <= en_d;
      end
      if (mask_ce) begin
        mask_q <= mask_d;
      end
    end
  end

  // The mask being written acts on the edge of the write itself,
  // so that an acknowledge takes effect without an extra cycle.
  assign mask_eff_o = mask_d;
  assign en_o       = en_q;

  always_comb begin
    pend_ext             = '0;
    pend_ext[NSRC-1:0]   = pend_i;
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL: rdata_o[EN_BIT] = en_q;
      SEL_PEND: rdata_o = pend_ext;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_latch_ctrl_pend_bank.sv
module irq_latch_ctrl_pend_bank #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [NSRC-1:0] cause_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] pend_o
);

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_cell
      logic pend_q, pend_d, set_c, clr_c;

      always_comb begin
        set_c  = en_i && cause_i[g] && !mask_i[g];
        clr_c  = mask_i[g] && !cause_i[g];
        pend_d = pend_q;
        if (set_c) begin
          pend_d = 1'b1;
        end else if (clr_c) begin
          pend_d = 1'b0;
        end
      end

      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
        end else if (set_c || clr_c) begin
          pend_q <= pend_d;
        end
      end

      assign pend_o[g] = pend_q;
    end
  endgenerate

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int unsigned NUM_STAT = 6,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_n_a,
  input  logic [NUM_STAT-1:0] stat_i,
  input  logic                es_ovf_i,
  input  logic                es_unf_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_n_o
);

  localparam int unsigned NSRC = NUM_STAT + 2;

  logic            rst_n_s;
  logic [NSRC-1:0] cause;
  logic [NSRC-1:0] mask_eff;
  logic [NSRC-1:0] pend;
  logic            en;

  irq_latch_ctrl_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_a (rst_n_a),
    .rst_n_o (rst_n_s)
  );

  irq_latch_ctrl_cause_gen #(.NUM_STAT(NUM_STAT)) u_cause (
    .clk_i    (clk_i),
    .rst_n    (rst_n_s),
    .stat_i   (stat_i),
    .es_ovf_i (es_ovf_i),
    .es_unf_i (es_unf_i),
    .cause_o  (cause)
  );

  irq_latch_ctrl_host_regs #(
    .NSRC   (NSRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_n      (rst_n_s),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pend_i     (pend),
    .rdata_o    (reg_rdata_o),
    .en_o       (en),
    .mask_eff_o (mask_eff)
  );

  irq_latch_ctrl_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk_i   (clk_i),
    .rst_n   (rst_n_s),
    .en_i    (en),
    .cause_i (cause),
    .mask_i  (mask_eff),
    .pend_o  (pend)
  );

  assign irq_n_o = !(en && (|pend));

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int unsigned NSRC = 8
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            en,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] cause,
  input logic            irq_n
);

  // R4
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(mask)) & ~pend) == '0));

  // R6
  clear_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~pend) & $past(cause)) == '0));

  // R7
  masked_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (((pend & ~$past(pend)) & $past(mask)) == '0));

  // R9
  disabled_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |=> ((pend & ~$past(pend)) == '0));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |-> irq_n);

  // R2
  new_pend_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && ((pend & ~$past(pend)) != '0)) |-> !irq_n);

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NSRC(NUM_STAT + 2)) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n_s),
  .en    (en),
  .pend  (pend),
  .mask  (mask_eff),
  .cause (cause),
  .irq_n (irq_n_o)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;

  localparam int unsigned NS = 6;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 8;
  localparam int unsigned OVF = NS;
  localparam int unsigned UNF = NS + 1;

  logic          clk = 1'b0;
  logic          rst_n_a;
  logic [NS-1:0] stat;
  logic          ovf, unf;
  logic          wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_latch_ctrl #(.NUM_STAT(NS), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i       (clk),
    .rst_n_a     (rst_n_a),
    .stat_i      (stat),
    .es_ovf_i    (ovf),
    .es_unf_i    (unf),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_n_o     (irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write lands on the next rising edge; returns at the following falling edge.
  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 2'd2;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 2'd2;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd_reg(2'd2, v); chk("R1 pending after reset", v, 0);
    rd_reg(2'd0, v); chk("R1 enable after reset", v, 0);
    chk("R1 irq_n after reset", irq_n, 1);
  endtask

  task automatic t_status_edges();
    logic [DW-1:0] v;
    wr_reg(2'd0, 8'h01);
    stat[1] = 1'b1;           // rise, sampled at next edge
    step();
    rd_reg(2'd2, v); chk("R2 rise sets pending", v, 8'h02);
    chk("R2 irq_n low", irq_n, 0);
    step(); step();
    rd_reg(2'd2, v); chk("R4 pending held", v, 8'h02);
    wr_reg(2'd1, 8'h02);
    rd_reg(2'd2, v); chk("R5 ack clears", v, 0);
    chk("R5 irq_n high", irq_n, 1);
    wr_reg(2'd1, 8'h00);
    stat[1] = 1'b0;           // fall
    step();
    rd_reg(2'd2, v); chk("R2 fall sets pending", v, 8'h02);
    wr_reg(2'd1, 8'h02);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd2, v); chk("R5 clear after fall", v, 0);
  endtask

  task automatic t_elastic();
    logic [DW-1:0] v;
    ovf = 1'b1;
    step();
    rd_reg(2'd2, v); chk("R3 overflow pending", v, 8'h01 << OVF);
    // acknowledge while the cause is still high
    wr_reg(2'd1, 8'h01 << OVF);
    rd_reg(2'd2, v); chk("R6 ack blocked by live cause", v, 8'h01 << OVF);
    chk("R6 irq_n still low", irq_n, 0);
    ovf = 1'b0;
    step();
    rd_reg(2'd2, v); chk("R6 clears once cause gone", v, 0);
    chk("R6 irq_n high", irq_n, 1);
    wr_reg(2'd1, 8'h00);
    unf = 1'b1;
    step();
    unf = 1'b0;
    step();
    rd_reg(2'd2, v); chk("R3 underflow pending", v, 8'h01 << UNF);
    wr_reg(2'd1, 8'h01 << UNF);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd2, v); chk("R5 underflow cleared", v, 0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    wr_reg(2'd1, 8'h01);
    stat[0] = 1'b1;
    step(); step();
    rd_reg(2'd2, v); chk("R7 masked status ignored", v, 0);
    chk("R7 irq_n high", irq_n, 1);
    ovf = 1'b1;
    step();
    ovf = 1'b0;
    // mask write colliding with a status toggle on the same edge
    @(negedge clk);
    wr = 1'b1; addr = 2'd1; wdata = 8'h08; stat[3] = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 2'd2;
    rd_reg(2'd2, v); chk("R7 mask write beats toggle", v, 8'h01 << OVF);
    wr_reg(2'd1, 8'h01 << OVF);
    wr_reg(2'd1, 8'h00);
    stat[0] = 1'b0;
    step();
    rd_reg(2'd2, v); chk("R8 unmasked source sets again", v, 8'h01);
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd1, 8'h00);
    stat[3] = 1'b0;
    step();
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd2, v); chk("R5 all clear", v, 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] v;
    stat[2] = 1'b1;
    step();
    rd_reg(2'd2, v); chk("R2 bit2 pending", v, 8'h04);
    wr_reg(2'd0, 8'h00);
    chk("R9 irq_n high when disabled", irq_n, 1);
    rd_reg(2'd2, v); chk("R9 pending kept", v, 8'h04);
    stat[4] = 1'b1;
    step();
    rd_reg(2'd2, v); chk("R9 no capture when disabled", v, 8'h04);
    wr_reg(2'd0, 8'h01);
    chk("R9 irq_n low after re-enable", irq_n, 0);
    wr_reg(2'd1, 8'h04);
    wr_reg(2'd1, 8'h00);
    chk("R5 irq_n high after ack", irq_n, 1);
  endtask

  task automatic t_readmap();
    logic [DW-1:0] v;
    wr_reg(2'd1, 8'hFF);
    rd_reg(2'd1, v); chk("R10 ack register reads zero", v, 0);
    rd_reg(2'd3, v); chk("R10 unused address reads zero", v, 0);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, v); chk("R10 control reads enable only", v, 8'h01);
    wr_reg(2'd1, 8'h00);
  endtask

  initial begin
    rst_n_a = 1'b0;
    stat = '0; ovf = 1'b0; unf = 1'b0;
    wr = 1'b0; addr = 2'd2; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n_a = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_status_edges();
    t_elastic();
    t_mask();
    t_enable();
    t_readmap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule